// File: doc/BRIEF.md
# Two-Round Interlocked Read Link

This block moves one word from a memory side to an I/O side over a single set of shared data lines. Address and data take turns on those lines. Three control wires carry the protocol: a read request, an acknowledge and a data-ready flag. The exchange runs two complete interlocked rounds. In the first round the requester offers the address and the responder acknowledges it. In the second round the responder offers the data and the requester acknowledges it. Neither side moves on until it has seen the other side's wire change.

The requester takes a one-cycle start pulse with an address. It returns the captured word together with a one-cycle done pulse. The responder looks the address up in a small computed array. It waits a programmable delay before it presents the result. Each side owns an output-enable for the shared lines. Every handshake input passes through a synchronizer before a state machine uses it, so the two sides may run on unrelated clocks. The acknowledge wire is the OR of the acknowledge driven by each side.

Top module: `hs_read_link`

## Requirements
- R1: While reset is asserted and right after it, read_req_o, ack_o, data_rdy_o, req_oe_o, rsp_oe_o and done_o are low and data_o is zero.
- R2: A start in idle makes the requester raise read_req_o and req_oe_o, and place the address zero-extended on bus_o.
- R3: The responder raises its acknowledge only after it has seen the read request high. The requester drops the read request and its output-enable only after it has seen the acknowledge high.
- R4: The responder drops its acknowledge only after it has seen the read request low.
- R5: data_rdy_o rises no sooner than RDY_DELAY cycles after the address acknowledge falls. It stays low while the responder sees the read request high.
- R6: done_o is a single-cycle pulse. Each accepted start produces exactly one pulse.
- R7: The requester drops its data acknowledge only after it has seen data_rdy_o low. The responder drops data_rdy_o and rsp_oe_o only after it has seen the acknowledge high.
- R8: req_oe_o and rsp_oe_o are never high in the same cycle.
- R9: A start that arrives before the done pulse of the running transaction is ignored. It launches no transaction and does not change the returned word.
- R10: With done_o, data_o holds the array word at the requested address a. That word is the low DATA_W bits of (a × 0x2F1B) XOR 0xC35A.
- R11: Transactions started one after another, each right after the previous done pulse, all complete with correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_req_i | input | 1 | Requester clock |
| clk_rsp_i | input | 1 | Responder clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle start pulse (requester clock) |
| addr_i | input | ADDR_W | Address to read, sampled with start_i |
| data_o | output | DATA_W | Word captured in the last completed read |
| done_o | output | 1 | One-cycle completion pulse |
| read_req_o | output | 1 | Read request wire |
| ack_o | output | 1 | Acknowledge wire (OR of both sides) |
| data_rdy_o | output | 1 | Data-ready wire |
| req_oe_o | output | 1 | Requester drives the shared lines |
| rsp_oe_o | output | 1 | Responder drives the shared lines |
| bus_o | output | DATA_W | Value on the shared lines (zero when undriven) |

## Verification
The bench builds the link with DATA_W=16, ADDR_W=4 and RDY_DELAY=5. It drives both clocks from one source. With a delay of 5 cycles, the programmed wait is longer than the two-stage synchronizer latency, so the measured gap from the address acknowledge falling to data-ready rising shows the delay itself and not the synchronizer. A 4-bit address lets the vector table reach both ends of the array, address 0 and address 15. A start injected a few cycles into a transaction lands while the address round is still open, which exercises the ignore rule.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [2:0] {
    RQ_IDLE, RQ_ADDR, RQ_WAIT, RQ_HOLD, RQ_CLOSE
  } rq_state_e;

  typedef enum logic [2:0] {
    RS_IDLE, RS_ACKED, RS_DELAY, RS_DRIVE
  } rs_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/hs_requester.sv
module hs_requester
  import hs_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ack_i,
  input  logic              rdy_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic              rrq_o,
  output logic              ack_o,
  output logic              oe_o,
  output logic [DATA_W-1:0] bus_o,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o
);
  rq_state_e         state_q;
  logic              ack_s, rdy_s;
  logic              rrq_q, ack_q, oe_q, done_q;
  logic [DATA_W-1:0] addr_q, data_q;

  hs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ack_i, rdy_i}),
    .q_o   ({ack_s, rdy_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RQ_IDLE;
      rrq_q   <= 1'b0;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        RQ_IDLE: if (start_i) begin
          addr_q  <= DATA_W'(addr_i);
          rrq_q   <= 1'b1;
          oe_q    <= 1'b1;
          state_q <= RQ_ADDR;
        end
        RQ_ADDR: if (ack_s) begin
          rrq_q   <= 1'b0;
          oe_q    <= 1'b0;
          state_q <= RQ_WAIT;
        end
        RQ_WAIT: if (rdy_s) begin
          data_q  <= bus_i;
          ack_q   <= 1'b1;
          state_q <= RQ_HOLD;
        end
        RQ_HOLD: if (!rdy_s) begin
          ack_q   <= 1'b0;
          state_q <= RQ_CLOSE;
        end
        // wait for own acknowledge to leave the synchronizer before finishing
        RQ_CLOSE: if (!ack_s) begin
          done_q  <= 1'b1;
          state_q <= RQ_IDLE;
        end
        default: state_q <= RQ_IDLE;
      endcase
    end
  end

  assign rrq_o  = rrq_q;
  assign ack_o  = ack_q;
  assign oe_o   = oe_q;
  assign bus_o  = addr_q;
  assign data_o = data_q;
  assign done_o = done_q;

  AST_REQ_DROP_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rrq_q) |-> $past(ack_s)); // R3
  AST_DATA_ACK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_q) |-> $past(!rdy_s)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R6
  AST_OE_WITH_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q == rrq_q); // R2
endmodule

// File: rtl/hs_responder.sv
module hs_responder
  import hs_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 4,
  parameter int RDY_DELAY   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rrq_i,
  input  logic              ack_i,
  input  logic [ADDR_W-1:0] bus_i,
  output logic              ack_o,
  output logic              rdy_o,
  output logic              oe_o,
  output logic [DATA_W-1:0] bus_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(RDY_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RDY_DELAY - 1);

  rs_state_e         state_q;
  logic              rrq_s, ack_s;
  logic              ack_q, rdy_q, oe_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = DATA_W'((32'(i) * 32'h2F1B) ^ 32'hC35A);
  end

  hs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({rrq_i, ack_i}),
    .q_o   ({rrq_s, ack_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RS_IDLE;
      ack_q   <= 1'b0;
      rdy_q   <= 1'b0;
      oe_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        RS_IDLE: if (rrq_s) begin
          addr_q  <= bus_i;
          ack_q   <= 1'b1;
          state_q <= RS_ACKED;
        end
        RS_ACKED: if (!rrq_s) begin
          ack_q   <= 1'b0;
          cnt_q   <= '0;
          state_q <= RS_DELAY;
        end
        // delay elapsed and own acknowledge seen low again
        RS_DELAY: begin
          if (cnt_q == CNT_LAST && !ack_s) begin
            data_q  <= rom[addr_q];
            rdy_q   <= 1'b1;
            oe_q    <= 1'b1;
            state_q <= RS_DRIVE;
          end else if (cnt_q != CNT_LAST) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RS_DRIVE: if (ack_s) begin
          rdy_q   <= 1'b0;
          oe_q    <= 1'b0;
          state_q <= RS_IDLE;
        end
        default: state_q <= RS_IDLE;
      endcase
    end
  end

  assign ack_o = ack_q;
  assign rdy_o = rdy_q;
  assign oe_o  = oe_q;
  assign bus_o = data_q;

  AST_ACK_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> $past(rrq_s)); // R3
  AST_ACK_DROP_AFTER_REQ_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_q) |-> $past(!rrq_s)); // R4
  AST_RDY_NOT_WITH_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_q |-> !rrq_s); // R5
  AST_RDY_DROP_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_q) |-> $past(ack_s)); // R7
endmodule

// File: rtl/hs_read_link.sv
module hs_read_link #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 4,
  parameter int RDY_DELAY   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_req_i,
  input  logic              clk_rsp_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o,
  output logic              read_req_o,
  output logic              ack_o,
  output logic              data_rdy_o,
  output logic              req_oe_o,
  output logic              rsp_oe_o,
  output logic [DATA_W-1:0] bus_o
);
  logic              rrq, rq_ack, rs_ack, rdy, rq_oe, rs_oe, ack;
  logic [DATA_W-1:0] rq_bus, rs_bus, bus;

  assign ack = rq_ack | rs_ack;
  assign bus = rq_oe ? rq_bus : (rs_oe ? rs_bus : '0);

  hs_requester #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_req (
    .clk_i  (clk_req_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .addr_i (addr_i),
    .ack_i  (ack),
    .rdy_i  (rdy),
    .bus_i  (bus),
    .rrq_o  (rrq),
    .ack_o  (rq_ack),
    .oe_o   (rq_oe),
    .bus_o  (rq_bus),
    .data_o (data_o),
    .done_o (done_o)
  );

  hs_responder #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RDY_DELAY(RDY_DELAY),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_rsp (
    .clk_i (clk_rsp_i),
    .rst_ni(rst_ni),
    .rrq_i (rrq),
    .ack_i (ack),
    .bus_i (bus[ADDR_W-1:0]),
    .ack_o (rs_ack),
    .rdy_o (rdy),
    .oe_o  (rs_oe),
    .bus_o (rs_bus)
  );

  assign read_req_o = rrq;
  assign ack_o      = ack;
  assign data_rdy_o = rdy;
  assign req_oe_o   = rq_oe;
  assign rsp_oe_o   = rs_oe;
  assign bus_o      = bus;

  AST_OE_EXCLUSIVE: assert property (@(posedge clk_req_i) disable iff (!rst_ni)
    !(rq_oe && rs_oe)); // R8
endmodule

// File: tb/hs_read_link_test.sv
module hs_read_link_test;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;
  localparam int DLY    = 5;
  localparam int NVEC   = 8;
  localparam logic [ADDR_W-1:0] VEC_ADDR [NVEC] = '{4'd0, 4'd15, 4'd7, 4'd1, 4'd8, 4'd14, 4'd3, 4'd10};
  localparam int VEC_GAP [NVEC] = '{0, 0, 3, 0, 7, 1, 0, 2};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] data, bus;
  logic done, rrq, ack, rdy, rq_oe, rs_oe;

  int n_chk = 0, n_bad = 0;
  int done_cnt = 0, overlap_cnt = 0, since_ack_fall = 0, last_gap = -1;
  logic ack_prev = 1'b0, rdy_prev = 1'b0;

  always #2 clk = ~clk;

  hs_read_link #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RDY_DELAY(DLY)) uut (
    .clk_req_i(clk), .clk_rsp_i(clk), .rst_ni(rst_n),
    .start_i(start), .addr_i(addr), .data_o(data), .done_o(done),
    .read_req_o(rrq), .ack_o(ack), .data_rdy_o(rdy),
    .req_oe_o(rq_oe), .rsp_oe_o(rs_oe), .bus_o(bus)
  );

  function automatic logic [DATA_W-1:0] exp_word(input logic [ADDR_W-1:0] a);
    return DATA_W'((32'(a) * 32'h2F1B) ^ 32'hC35A);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (rq_oe && rs_oe) overlap_cnt++;
      if (done) done_cnt++;
      if (ack_prev && !ack) since_ack_fall = 0;
      else since_ack_fall++;
      if (!rdy_prev && rdy) last_gap = since_ack_fall;
    end
    ack_prev = ack;
    rdy_prev = rdy;
  end

  task automatic pulse_start(input logic [ADDR_W-1:0] a);
    addr  = a;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!done && t < 300) begin
      @(negedge clk);
      t++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL %s actual=timeout expected=done", req);
    end
  endtask

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ctrl", {rrq, ack, rdy, rq_oe, rs_oe, done}, 6'b0);
    check("R1 data", data, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {rrq, ack, rdy, rq_oe, rs_oe, done, data}, '0);

    // vector table walk (R10, R11)
    for (int i = 0; i < NVEC; i++) begin
      int dc;
      dc = done_cnt;
      pulse_start(VEC_ADDR[i]);
      if (i == 0) begin
        // R2: request and address visible one cycle after start
        check("R2 read_req", {rrq, rq_oe}, 2'b11);
        check("R2 bus addr", bus, DATA_W'(VEC_ADDR[i]));
      end
      wait_done("R11 done");
      check("R10 data", data, exp_word(VEC_ADDR[i]));
      check("R5 delay gap", (last_gap >= DLY), 1'b1);
      @(negedge clk);
      // R6: single-cycle pulse, one per start
      check("R6 pulse width", done, 1'b0);
      check("R6 pulse count", done_cnt - dc, 1);
      repeat (VEC_GAP[i]) @(negedge clk);
    end

    // R9: second start while busy is ignored
    begin
      int dc;
      dc = done_cnt;
      pulse_start(4'd6);
      repeat (2) @(negedge clk);
      pulse_start(4'd9);
      wait_done("R9 done");
      check("R9 data kept", data, exp_word(4'd6));
      repeat (60) @(negedge clk);
      check("R9 single done", done_cnt - dc, 1);
      check("R9 idle lines", {rrq, ack, rdy, rq_oe, rs_oe}, 5'b0);
    end

    // R3/R4/R7: idle lines quiet between transactions, full round trip again
    pulse_start(4'd12);
    wait_done("R7 done");
    check("R7 data", data, exp_word(4'd12));
    repeat (6) @(negedge clk);
    check("R3 R4 R7 released", {rrq, ack, rdy, rq_oe, rs_oe}, 5'b0);

    // R8 overlap monitor over whole run
    check("R8 overlap", overlap_cnt, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule